// File: doc/BRIEF.md
# Lockable Watchdog Timer with Debug Freeze

This block is a watchdog timer clocked by its own watchdog clock. An up counter runs while the watchdog is enabled. When it reaches the interval chosen by a 3-bit select, it raises a time-out. The interval is 2^(4+2n) clocks, so it runs from 16 to 262144 clocks. A time-out sets an interrupt flag. It sets a wake-up flag if wake-ups are enabled. It also opens a grace window of 1024 counting clocks. If software does not restart the counter before that window ends, and resets are enabled, the block pulses a system reset request.

All control and status sits in one 32-bit register on a simple write strobe / read data bus. Three fields are protected: the debug override, the interval select and the enable. They change only while the unlock input is high. A debug-halt input freezes the counter and the grace window, unless the debug override bit is set.

Top module: `wdog_top`

## Requirements
- R1: After reset the register reads 0x0000_0700 (interval select = 3'b111, all other bits 0), and irq, wake and rst_req are low.
- R2: With enable set, the time-out flag (bit 3) sets exactly 2^(4+2n) counting clocks after the counter starts from zero, where n is the interval select (bits 10:8).
- R3: While enable (bit 7) is 0 the counter is cleared, so a re-enabled watchdog waits the full interval again.
- R4: With the debug override (bit 31) at 0, a high dbg_halt holds the counter. With the override at 1, the counter runs regardless of dbg_halt.
- R5: Writes to bit 31, bits 10:8 and bit 7 take effect only while unlock is high. Without unlock those fields keep their value, while the other writable bits still update.
- R6: Bits 30:11 and the counter-restart bit 0 always read as 0.
- R7: irq is high exactly when the time-out flag and the interrupt enable (bit 6) are both 1.
- R8: A time-out sets the wake flag (bit 5) and drives wake high only when wake enable (bit 4) is 1.
- R9: With reset enable (bit 1) set, rst_req pulses high for one clock, and the reset flag (bit 2) sets, 1024 counting clocks after the time-out that opened the grace window.
- R10: Writing 1 to bit 0 clears the counter and closes an open grace window.
- R11: Bits 5, 3 and 2 clear when written with 1. Writing 0 to them leaves them unchanged, and a time-out in the same cycle wins over the clear.
- R12: With reset enable at 0, the grace window runs out without a reset request, and the reset flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock | input | 1 | High allows writes to the protected fields |
| dbg_halt | input | 1 | Processor held by the debugger |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| irq | output | 1 | Time-out interrupt |
| wake | output | 1 | Wake-up request |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The assertions assume that bus_wr, bus_wdata, unlock and dbg_halt are synchronous to the watchdog clock and settle well before each rising edge. The bench keeps to this by driving every input one nanosecond after an edge. The freeze property assumes that no write occurs while the halt is held, and the bench issues no write during its frozen stretch. The bench restarts the counter only by disabling or by the restart bit. It counts every interval and grace window in edges from the write that set them up.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // register layout: software decodes these positions
  localparam int TSEL_W   = 3;
  localparam int B_OVR    = 31;
  localparam int B_TSEL   = 8;
  localparam int B_EN     = 7;
  localparam int B_IE     = 6;
  localparam int B_WKF    = 5;
  localparam int B_WKE    = 4;
  localparam int B_TOF    = 3;
  localparam int B_RSTF   = 2;
  localparam int B_RSTE   = 1;
  localparam int B_CLR    = 0;
  localparam logic [TSEL_W-1:0] TSEL_RST = '1;

  typedef struct packed {
    logic              ovr;
    logic [TSEL_W-1:0] tsel;
    logic              en;
    logic              ie;
    logic              wke;
    logic              rste;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 4,
  parameter int EXP_STEP = 2,
  parameter int CNT_W    = BASE_EXP + EXP_STEP * ((1 << TSEL_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ovr,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              dbg_halt,
  input  logic              clr_cmd,
  output logic              run,
  output logic              tout_evt,
  output logic [CNT_W-1:0]  cnt
);
  localparam int SH_W = $clog2(CNT_W + 1);
  localparam logic [CNT_W:0]   SPAN_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE  = 1;

  // last count value before a time-out: 2^(BASE_EXP + EXP_STEP*sel) - 1
  function automatic logic [CNT_W-1:0] tout_last(input logic [TSEL_W-1:0] sel);
    logic [SH_W-1:0] sh;
    logic [CNT_W:0]  span;
    sh   = SH_W'(BASE_EXP) + SH_W'(EXP_STEP) * SH_W'(sel);
    span = SPAN_ONE << sh;
    return span[CNT_W-1:0] - CNT_ONE;
  endfunction

  assign run      = en && (ovr || !dbg_halt);
  assign tout_evt = run && !clr_cmd && (cnt >= tout_last(tsel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || clr_cmd)   cnt <= '0;
    else if (tout_evt)         cnt <= '0;
    else if (run)              cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/wdog_graceWin.sv
`timescale 1ns/1ps
module wdog_grace_win #(
  parameter int WIN_LEN = 1024,
  parameter int WIN_W   = $clog2(WIN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run,
  input  logic clr_cmd,
  input  logic tout_evt,
  input  logic rste,
  output logic win_open,
  output logic rst_evt,
  output logic rst_req
);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [WIN_W-1:0] WIN_ONE  = 1;

  logic [WIN_W-1:0] win_cnt;
  logic             expire_evt;

  assign expire_evt = en && run && !clr_cmd && win_open && (win_cnt == WIN_LAST);
  assign rst_evt    = expire_evt && rste;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_cnt  <= '0;
    end else if (!en || clr_cmd) begin
      win_open <= 1'b0;
      win_cnt  <= '0;
    end else if (run) begin
      if (win_open) begin
        if (expire_evt) begin
          win_open <= 1'b0;
          win_cnt  <= '0;
        end else begin
          win_cnt  <= win_cnt + WIN_ONE;
        end
      end else if (tout_evt) begin
        win_open <= 1'b1;
        win_cnt  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= rst_evt;
  end
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlock,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        tout_evt,
  input  logic        rst_evt,
  output wdog_ctrl_t  ctrl,
  output logic        tof,
  output logic        wkf,
  output logic        rstf,
  output logic        clr_cmd,
  output logic [31:0] bus_rdata
);
  logic prot_wr;
  logic unused_rsvd;

  assign prot_wr     = bus_wr && unlock;
  assign clr_cmd     = bus_wr && bus_wdata[B_CLR];
  assign unused_rsvd = ^bus_wdata[30:11];

  // protected fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.ovr  <= 1'b0;
      ctrl.tsel <= TSEL_RST;
      ctrl.en   <= 1'b0;
    end else if (prot_wr) begin
      ctrl.ovr  <= bus_wdata[B_OVR];
      ctrl.tsel <= bus_wdata[B_TSEL +: TSEL_W];
      ctrl.en   <= bus_wdata[B_EN];
    end
  end

  // open fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.ie   <= 1'b0;
      ctrl.wke  <= 1'b0;
      ctrl.rste <= 1'b0;
    end else if (bus_wr) begin
      ctrl.ie   <= bus_wdata[B_IE];
      ctrl.wke  <= bus_wdata[B_WKE];
      ctrl.rste <= bus_wdata[B_RSTE];
    end
  end

  // sticky flags: event set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tof  <= 1'b0;
      wkf  <= 1'b0;
      rstf <= 1'b0;
    end else begin
      if (tout_evt)                          tof  <= 1'b1;
      else if (bus_wr && bus_wdata[B_TOF])   tof  <= 1'b0;
      if (tout_evt && ctrl.wke)              wkf  <= 1'b1;
      else if (bus_wr && bus_wdata[B_WKF])   wkf  <= 1'b0;
      if (rst_evt)                           rstf <= 1'b1;
      else if (bus_wr && bus_wdata[B_RSTF])  rstf <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata                        = '0;
    bus_rdata[B_OVR]                 = ctrl.ovr;
    bus_rdata[B_TSEL +: TSEL_W]      = ctrl.tsel;
    bus_rdata[B_EN]                  = ctrl.en;
    bus_rdata[B_IE]                  = ctrl.ie;
    bus_rdata[B_WKF]                 = wkf;
    bus_rdata[B_WKE]                 = ctrl.wke;
    bus_rdata[B_TOF]                 = tof;
    bus_rdata[B_RSTF]                = rstf;
    bus_rdata[B_RSTE]                = ctrl.rste;
  end
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 4,
  parameter int EXP_STEP = 2,
  parameter int WIN_LEN  = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlock,
  input  logic        dbg_halt,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wake,
  output logic        rst_req
);
  localparam int CNT_W = BASE_EXP + EXP_STEP * ((1 << TSEL_W) - 1);
  localparam int WIN_W = $clog2(WIN_LEN);

  wdog_ctrl_t       ctrl;
  logic             tof, wkf, rstf;
  logic             clr_cmd, run, tout_evt, rst_evt, win_open;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlock   (unlock),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .tout_evt (tout_evt),
    .rst_evt  (rst_evt),
    .ctrl     (ctrl),
    .tof      (tof),
    .wkf      (wkf),
    .rstf     (rstf),
    .clr_cmd  (clr_cmd),
    .bus_rdata(bus_rdata)
  );

  wdog_counter #(
    .BASE_EXP(BASE_EXP),
    .EXP_STEP(EXP_STEP),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl.en),
    .ovr     (ctrl.ovr),
    .tsel    (ctrl.tsel),
    .dbg_halt(dbg_halt),
    .clr_cmd (clr_cmd),
    .run     (run),
    .tout_evt(tout_evt),
    .cnt     (cnt)
  );

  wdog_grace_win #(
    .WIN_LEN(WIN_LEN),
    .WIN_W  (WIN_W)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl.en),
    .run     (run),
    .clr_cmd (clr_cmd),
    .tout_evt(tout_evt),
    .rste    (ctrl.rste),
    .win_open(win_open),
    .rst_evt (rst_evt),
    .rst_req (rst_req)
  );

  assign irq  = tof && ctrl.ie;
  assign wake = wkf;
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unlock,
  input logic             dbg_halt,
  input logic             bus_wr,
  input logic [31:0]      bus_rdata,
  input logic             wake,
  input logic             rst_req,
  input logic             en,
  input logic             ovr,
  input logic [2:0]       tsel,
  input logic             rste,
  input logic             wke,
  input logic             tof,
  input logic             rstf,
  input logic             tout_evt,
  input logic             clr_cmd,
  input logic [CNT_W-1:0] cnt,
  input logic             win_open
);
  // R2
  tout_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_evt |=> tof);

  // R3
  dis_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbg_halt && !ovr && !bus_wr) |=> (cnt == $past(cnt)));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlock) |=> ($stable(tsel) && $stable(en) && $stable(ovr)));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[30:11] == '0) && !bus_rdata[0]);

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_evt && !wke && !wake) |=> !wake);

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R9
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rstf);

  // R12
  rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rste));

  // R10
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> ((cnt == '0) && !win_open));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .unlock   (unlock),
  .dbg_halt (dbg_halt),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .wake     (wake),
  .rst_req  (rst_req),
  .en       (ctrl.en),
  .ovr      (ctrl.ovr),
  .tsel     (ctrl.tsel),
  .rste     (ctrl.rste),
  .wke      (ctrl.wke),
  .tof      (tof),
  .rstf     (rstf),
  .tout_evt (tout_evt),
  .clr_cmd  (clr_cmd),
  .cnt      (cnt),
  .win_open (win_open)
);

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;
  localparam logic [31:0] M_OVR  = 32'h8000_0000;
  localparam logic [31:0] M_EN   = 32'h0000_0080;
  localparam logic [31:0] M_IE   = 32'h0000_0040;
  localparam logic [31:0] M_WKF  = 32'h0000_0020;
  localparam logic [31:0] M_WKE  = 32'h0000_0010;
  localparam logic [31:0] M_TOF  = 32'h0000_0008;
  localparam logic [31:0] M_RSTF = 32'h0000_0004;
  localparam logic [31:0] M_RSTE = 32'h0000_0002;
  localparam logic [31:0] M_CLR  = 32'h0000_0001;
  localparam logic [31:0] M_RSVD = 32'h7FFF_F800;
  localparam logic [2:0]  O_IRQ = 3'b001, O_WAKE = 3'b010, O_RST = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake, rst_req;

  always #2.5 clk = ~clk;

  wdog_top u_dut (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .dbg_halt(dbg_halt),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake), .rst_req(rst_req)
  );

  typedef struct {
    logic [31:0] dmask;
    logic [31:0] dexp;
    logic [2:0]  omask;
    logic [2:0]  oexp;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_run = 0;
  int   n_fail = 0;

  function automatic logic [31:0] ts(input int n);
    return 32'(n) << 8;
  endfunction

  task automatic expect_st(input logic [31:0] dmask, input logic [31:0] dexp,
                           input logic [2:0] omask, input logic [2:0] oexp,
                           input string tag);
    exp_t e;
    e.dmask = dmask; e.dexp = dexp; e.omask = omask; e.oexp = oexp; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares queued expectations at the falling edge
  always begin
    exp_t e;
    @(negedge clk);
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      n_run++;
      if ((((bus_rdata ^ e.dexp) & e.dmask) != 0) ||
          ((({rst_req, wake, irq} ^ e.oexp) & e.omask) != 0)) begin
        n_fail++;
        $display("FAIL %s: rdata=%h exp=%h (mask %h) outs=%b exp=%b (mask %b)",
                 e.tag, bus_rdata, e.dexp, e.dmask, {rst_req, wake, irq}, e.oexp, e.omask);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  bit done = 0;

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    expect_st('1, 32'h0000_0700, 3'b111, 3'b000, "R1 reset value");

    // R5 locked write: protected fields hold, ie still updates
    unlock = 1'b0;
    wr(M_EN | ts(0) | M_IE);
    expect_st('1, 32'h0000_0740, 3'b000, 3'b000, "R5 locked write");
    tick(40);
    expect_st(M_TOF, 32'h0, O_IRQ, 3'b000, "R5 no count while locked-off");

    // R2 interval 16 with n=0
    unlock = 1'b1;
    wr(M_EN | ts(0));
    tick(15);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R2 before time-out");
    tick(1);
    expect_st(M_TOF | M_WKF, M_TOF, O_WAKE, 3'b000, "R2 time-out flag / R8 no wake");
    // R12 no reset request without reset enable
    tick(1024);
    expect_st(M_RSTF, 32'h0, O_RST, 3'b000, "R12 window end no request");
    tick(1);
    expect_st(M_RSTF, 32'h0, O_RST, 3'b000, "R12 window end+1 no request");

    // R7 irq follows flag and enable
    wr(M_EN | ts(0) | M_IE);
    expect_st(M_TOF, M_TOF, O_IRQ, O_IRQ, "R7 irq high");
    wr(M_EN | ts(0));
    expect_st(M_TOF, M_TOF, O_IRQ, 3'b000, "R7 irq low with ie=0");

    // R11 write-zero keeps, write-one clears
    wr(ts(0));
    wr(ts(0));
    expect_st(M_TOF | M_EN, M_TOF, 3'b000, 3'b000, "R11 zero write keeps flag");
    wr(ts(0) | M_TOF);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R11 one write clears flag");

    // R3 disable clears counter
    wr(M_EN | ts(0));
    tick(10);
    wr(ts(0));
    tick(3);
    wr(M_EN | ts(0));
    tick(15);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R3 full interval after re-enable");
    tick(1);
    expect_st(M_TOF, M_TOF, 3'b000, 3'b000, "R3 time-out after re-enable");
    wr(ts(0) | M_TOF);

    // R4 debug freeze
    dbg_halt = 1'b1;
    wr(M_EN | ts(0));
    tick(40);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R4 frozen while halted");
    dbg_halt = 1'b0;
    tick(15);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R4 resumes from zero");
    tick(1);
    expect_st(M_TOF, M_TOF, 3'b000, 3'b000, "R4 time-out after release");
    wr(ts(0) | M_TOF);

    // R4 override keeps counting under halt
    dbg_halt = 1'b1;
    wr(M_OVR | M_EN | ts(0));
    tick(15);
    expect_st(M_TOF, 32'h0, 3'b000, 3'b000, "R4 override before time-out");
    tick(1);
    expect_st(M_TOF, M_TOF, 3'b000, 3'b000, "R4 override time-out");
    wr(ts(0) | M_TOF);
    dbg_halt = 1'b0;

    // R8 wake with enable
    wr(M_EN | ts(0) | M_WKE);
    tick(16);
    expect_st(M_WKF | M_TOF, M_WKF | M_TOF, O_WAKE, O_WAKE, "R8 wake set");
    wr(ts(0) | M_TOF | M_WKF);
    expect_st(M_WKF | M_TOF, 32'h0, O_WAKE, 3'b000, "R11 wake flag cleared");

    // R9 reset request after grace window
    wr(M_EN | ts(0) | M_RSTE);
    tick(16);
    tick(1023);
    expect_st(M_RSTF, 32'h0, O_RST, 3'b000, "R9 before window end");
    tick(1);
    expect_st(M_RSTF, M_RSTF, O_RST, O_RST, "R9 reset pulse");
    tick(1);
    expect_st(M_RSTF, M_RSTF, O_RST, 3'b000, "R9 pulse one cycle");
    wr(ts(0) | M_TOF | M_RSTF);
    expect_st(M_RSTF, 32'h0, 3'b000, 3'b000, "R11 reset flag cleared");

    // R10 restart closes window
    wr(M_EN | ts(1) | M_RSTE);
    tick(64 + 500);
    wr(M_EN | ts(1) | M_RSTE | M_CLR);
    expect_st(M_CLR | M_TOF, M_TOF, 3'b000, 3'b000, "R6 restart bit reads 0");
    tick(523);
    expect_st(M_RSTF, 32'h0, O_RST, 3'b000, "R10 old window closed");
    tick(564);
    expect_st(M_RSTF, 32'h0, O_RST, 3'b000, "R10 new window not yet over");
    tick(1);
    expect_st(M_RSTF, M_RSTF, O_RST, O_RST, "R10 new window reset pulse");
    wr(ts(1) | M_TOF | M_RSTF);

    // R6 reserved bits
    wr(32'hFFFF_FFFF);
    expect_st(M_RSVD | M_CLR, 32'h0, 3'b000, 3'b000, "R6 reserved read zero");
    expect_st('1, 32'h8000_07D2, 3'b000, 3'b000, "R6 full readback");
    unlock = 1'b0;
    wr(32'h0);
    expect_st('1, M_OVR | ts(7) | M_EN, 3'b000, 3'b000, "R5 lock keeps protected");
    unlock = 1'b1;
    wr(32'h0);
    expect_st('1, 32'h0, 3'b111, 3'b000, "R5 unlocked write");

    tick(2);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<%0d", cyc, 200000);
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule